// File: doc/BRIEF.md
# Proxy-Mapped DMA Initiation Controller

This block lets unprivileged code launch a single-page DMA transfer with two ordinary bus accesses and no kernel call. The physical address space is split by its high-order bits into real memory, a memory proxy window and a device proxy window. A proxy address maps to its real counterpart by clearing the top address bit. A store of a positive byte count to a proxy address arms the controller with a destination. A following load from a proxy address in the other window supplies the source and starts the transfer. Every proxy load also returns a packed status word, so the same load reports whether the launch worked.

Sequences the hardware cannot honour are rejected and send the controller back to idle. These include memory-to-memory and device-to-device requests, misaligned requests and requests that cross a page. A single negative-count store aborts a half-built sequence, which is how a context switch clears another process's setup. A built-in byte mover walks both addresses one 32-bit word per ready cycle and pulses a completion flag at the end.

Top module: `proxy_dma_ctrl`

## Requirements
- R1: After reset the controller is idle, `mv_req`, `xfer_done` and `bus_rvalid` are low, and a status load reports INVALID=1, INITIATION=1 and remaining bytes 0.
- R2: An address with bit AW-1 set is a proxy address. Within it, bit AW-2 = 1 selects the device window and 0 selects the memory window. The real address is the proxy address with bit AW-1 cleared. Accesses with bit AW-1 clear produce no status and change no state.
- R3: A proxy store of a positive count (bit 31 clear, non-zero) while idle or armed arms the controller. It loads the destination with the translated address and the count, overwriting any earlier pair.
- R4: A proxy store with bit 31 set while armed returns to idle. A store of zero has no effect in any state.
- R5: A proxy load while armed, from the window opposite the destination, that passes the checks of R7, loads the source with the translated address and enters the transferring state. Its status carries INITIATION=0.
- R6: A load while armed from the same window as the destination returns to idle without moving data. Its status has WRONG-SPACE=1 and INITIATION=1.
- R7: A launch load returns to idle with ERROR=1 and INITIATION=1 if any of these holds: the destination, the source or the count is not a multiple of 4; the count exceeds one page; or either offset-in-page plus count exceeds the page size.
- R8: The status word has INITIATION at bit 0, TRANSFERRING at bit 1, INVALID (idle) at bit 2, MATCH at bit 3, WRONG-SPACE at bit 4 and ERROR at bit 5. Remaining bytes sit at bits 8 and up, and read zero when idle. The word describes the state just before the load and appears on `bus_rdata` with `bus_rvalid` one cycle after the load.
- R9: MATCH is 1 only while transferring and when the translated load address equals the source base of the running transfer.
- R10: While transferring with bytes left, `mv_req` is high. Each cycle that `mv_ready` is also high moves one word: both addresses advance by 4 and the count drops by 4. With `mv_ready` low, both addresses hold.
- R11: The cycle after the final word, `xfer_done` is high for exactly one cycle and the controller is idle again.
- R12: Stores of any value and loads during a transfer do not disturb it. Loads while idle change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = store, 0 = load |
| bus_addr | input | AW | Physical access address |
| bus_wdata | input | 32 | Store data (signed byte count) |
| bus_rvalid | output | 1 | Status word valid |
| bus_rdata | output | 32 | Status word |
| mv_req | output | 1 | Mover wants to move a word |
| mv_ready | input | 1 | Memory/device side accepts a word this cycle |
| mv_src_addr | output | AW | Current real source address |
| mv_dst_addr | output | AW | Current real destination address |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
The status word of a load is due on the cycle after the edge that samples the load. A queued expected word is therefore popped only when `bus_rvalid` is seen. Any status word that arrives with the queue empty counts as an error, which catches accesses that should have been silent. Word moves happen on the edge following a cycle with `mv_req` and `mv_ready` both high, so the expected address pair is compared just after the falling edge that precedes that edge. The completion pulse is checked on the exact cycle: N cycles after the ready is given for an N-word transfer, and low again one cycle later.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_MOVE  = 2'd2
  } pdma_state_e;

  localparam int unsigned STAT_W   = 32;
  localparam int unsigned B_INIT   = 0;
  localparam int unsigned B_XFER   = 1;
  localparam int unsigned B_IDLE   = 2;
  localparam int unsigned B_MATCH  = 3;
  localparam int unsigned B_WRONG  = 4;
  localparam int unsigned B_ERR    = 5;
  localparam int unsigned REM_LSB  = 8;
  localparam int unsigned WORD_B   = 4;
endpackage

// File: rtl/pdma_addr_decode.sv
module pdma_addr_decode #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr,
  output logic          proxy_hit,
  output logic          dev_hit,
  output logic [AW-1:0] real_addr
);
  always_comb begin
    proxy_hit = addr[AW-1];
    dev_hit   = addr[AW-2];
    real_addr = addr;
    real_addr[AW-1] = 1'b0;
  end
endmodule

// File: rtl/pdma_fsm.sv
module pdma_fsm
  import pdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_vld,
  input  logic        acc_wr,
  input  logic        acc_dev,
  input  logic        cnt_pos,
  input  logic        cnt_neg,
  input  logic        req_fault,
  input  logic        last_beat,
  output pdma_state_e state_q,
  output logic        ld_dst,
  output logic        start,
  output logic        bad_load,
  output logic        fault_load
);
  pdma_state_e state_d;
  logic        dst_dev_q;
  logic        is_load;
  logic        armed;

  always_comb begin
    is_load    = acc_vld && !acc_wr;
    armed      = (state_q == ST_ARMED);
    ld_dst     = acc_vld && acc_wr && cnt_pos && (state_q != ST_MOVE);
    bad_load   = is_load && armed && (acc_dev == dst_dev_q);
    fault_load = is_load && armed && !bad_load && req_fault;
    start      = is_load && armed && !bad_load && !req_fault;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ld_dst) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (ld_dst)                              state_d = ST_ARMED;
        else if (acc_vld && acc_wr && cnt_neg)   state_d = ST_IDLE;
        else if (bad_load || fault_load)         state_d = ST_IDLE;
        else if (start)                          state_d = ST_MOVE;
      end
      ST_MOVE: begin
        if (last_beat) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dst_dev_q <= 1'b0;
    else if (ld_dst) dst_dev_q <= acc_dev;
  end
endmodule

// File: rtl/pdma_mover.sv
module pdma_mover
  import pdma_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_dst,
  input  logic [AW-1:0] dst_in,
  input  logic [CW-1:0] cnt_in,
  input  logic          start,
  input  logic [AW-1:0] src_in,
  input  logic          run,
  input  logic          mv_ready,
  output logic          mv_req,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output logic [AW-1:0] base_q,
  output logic          last_beat,
  output logic          done_q
);
  localparam logic [CW-1:0] STEP_C = CW'(WORD_B);
  localparam logic [AW-1:0] STEP_A = AW'(WORD_B);

  logic step;

  always_comb begin
    mv_req    = run && (cnt_q != '0);
    step      = mv_req && mv_ready;
    last_beat = step && (cnt_q <= STEP_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dst_q <= '0;
    else if (ld_dst) dst_q <= dst_in;
    else if (step)   dst_q <= dst_q + STEP_A;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= '0;
    else if (start)  src_q <= src_in;
    else if (step)   src_q <= src_q + STEP_A;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_q <= '0;
    else if (start) base_q <= src_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (ld_dst)    cnt_q <= cnt_in;
    else if (last_beat) cnt_q <= '0;
    else if (step)      cnt_q <= cnt_q - STEP_C;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= last_beat;
  end
endmodule

// File: rtl/proxy_dma_ctrl.sv
module proxy_dma_ctrl
  import pdma_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic          bus_rvalid,
  output logic [31:0]   bus_rdata,
  output logic          mv_req,
  input  logic          mv_ready,
  output logic [AW-1:0] mv_src_addr,
  output logic [AW-1:0] mv_dst_addr,
  output logic          xfer_done
);
  localparam int unsigned OFF_W = $clog2(PAGE_BYTES);
  localparam int unsigned CW    = OFF_W + 1;
  localparam logic [CW:0] PAGE_E = (CW+1)'(PAGE_BYTES);

  logic [1:0]    rst_pipe;
  logic          rst_int;
  logic          proxy_hit, dev_hit;
  logic [AW-1:0] real_addr;
  logic          acc_vld, cnt_pos, cnt_neg, big_in;
  logic          big_q;
  logic          req_fault;
  logic          ld_dst, start, bad_load, fault_load, last_beat;
  pdma_state_e   state_q;
  logic [AW-1:0] src_q, dst_q, base_q;
  logic [CW-1:0] cnt_q;
  logic [CW:0]   dst_end, src_end;
  logic [31:0]   stat_d;
  logic          is_load;

  // reset: asserts at once, leaves after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  pdma_addr_decode #(.AW(AW)) u_dec (
    .addr      (bus_addr),
    .proxy_hit (proxy_hit),
    .dev_hit   (dev_hit),
    .real_addr (real_addr)
  );

  always_comb begin
    acc_vld = bus_valid && proxy_hit;
    is_load = acc_vld && !bus_write;
    cnt_pos = !bus_wdata[31] && (bus_wdata != '0);
    cnt_neg = bus_wdata[31];
    big_in  = cnt_pos && (bus_wdata > 32'(PAGE_BYTES));
    dst_end = (CW+1)'(dst_q[OFF_W-1:0]) + (CW+1)'(cnt_q);
    src_end = (CW+1)'(real_addr[OFF_W-1:0]) + (CW+1)'(cnt_q);
    req_fault = (dst_q[1:0] != 2'b00) || (real_addr[1:0] != 2'b00) ||
                (cnt_q[1:0] != 2'b00) || big_q ||
                (dst_end > PAGE_E) || (src_end > PAGE_E);
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int)    big_q <= 1'b0;
    else if (ld_dst) big_q <= big_in;
  end

  pdma_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_int),
    .acc_vld    (acc_vld),
    .acc_wr     (bus_write),
    .acc_dev    (dev_hit),
    .cnt_pos    (cnt_pos),
    .cnt_neg    (cnt_neg),
    .req_fault  (req_fault),
    .last_beat  (last_beat),
    .state_q    (state_q),
    .ld_dst     (ld_dst),
    .start      (start),
    .bad_load   (bad_load),
    .fault_load (fault_load)
  );

  pdma_mover #(.AW(AW), .CW(CW)) u_mov (
    .clk       (clk),
    .rst_n     (rst_int),
    .ld_dst    (ld_dst),
    .dst_in    (real_addr),
    .cnt_in    (bus_wdata[CW-1:0]),
    .start     (start),
    .src_in    (real_addr),
    .run       (state_q == ST_MOVE),
    .mv_ready  (mv_ready),
    .mv_req    (mv_req),
    .src_q     (src_q),
    .dst_q     (dst_q),
    .cnt_q     (cnt_q),
    .base_q    (base_q),
    .last_beat (last_beat),
    .done_q    (xfer_done)
  );

  always_comb begin
    stat_d          = '0;
    stat_d[B_INIT]  = !start;
    stat_d[B_XFER]  = (state_q == ST_MOVE);
    stat_d[B_IDLE]  = (state_q == ST_IDLE);
    stat_d[B_MATCH] = (state_q == ST_MOVE) && (real_addr == base_q);
    stat_d[B_WRONG] = bad_load;
    stat_d[B_ERR]   = fault_load;
    stat_d[REM_LSB +: CW] = (state_q == ST_IDLE) ? '0 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) bus_rvalid <= 1'b0;
    else          bus_rvalid <= is_load;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int)     bus_rdata <= '0;
    else if (is_load) bus_rdata <= stat_d;
  end

  assign mv_src_addr = src_q;
  assign mv_dst_addr = dst_q;
endmodule

// File: rtl/pdma_checker.sv
module pdma_checker
  import pdma_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 13
) (
  input logic          clk,
  input logic          rst_int,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input pdma_state_e   state_q,
  input logic [CW-1:0] cnt_q,
  input logic          mv_req,
  input logic          mv_ready,
  input logic          xfer_done,
  input logic          bus_rvalid,
  input logic [31:0]   bus_rdata
);
  a_r3_store_arms: assert property (@(posedge clk) disable iff (!rst_int)
    (bus_valid && bus_write && bus_addr[AW-1] && !bus_wdata[31] &&
     (bus_wdata != '0) && (state_q != ST_MOVE))
    |=> (state_q == ST_ARMED) && (cnt_q == $past(bus_wdata[CW-1:0])));

  a_r4_abort: assert property (@(posedge clk) disable iff (!rst_int)
    (bus_valid && bus_write && bus_addr[AW-1] && bus_wdata[31] &&
     (state_q == ST_ARMED)) |=> (state_q == ST_IDLE));

  a_r2_outside_ignored: assert property (@(posedge clk) disable iff (!rst_int)
    (bus_valid && !bus_addr[AW-1] && (state_q != ST_MOVE)) |=> $stable(state_q));

  a_r8_status_timing: assert property (@(posedge clk) disable iff (!rst_int)
    bus_rvalid |-> $past(bus_valid && !bus_write && bus_addr[AW-1]));

  a_r6_wrong_rejects: assert property (@(posedge clk) disable iff (!rst_int)
    (bus_rvalid && bus_rdata[B_WRONG]) |-> (bus_rdata[B_INIT] && (state_q == ST_IDLE)));

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_int)
    ((state_q == ST_MOVE) && mv_req && mv_ready && (cnt_q > CW'(WORD_B)))
    |=> (cnt_q == $past(cnt_q) - CW'(WORD_B)));

  a_r12_move_holds: assert property (@(posedge clk) disable iff (!rst_int)
    ((state_q == ST_MOVE) && !(mv_req && mv_ready && (cnt_q <= CW'(WORD_B))))
    |=> (state_q == ST_MOVE));

  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_int)
    xfer_done |-> ((state_q == ST_IDLE) && !mv_req));
endmodule

bind proxy_dma_ctrl pdma_checker #(.AW(AW), .CW(CW)) u_pdma_chk (
  .clk        (clk),
  .rst_int    (rst_int),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .state_q    (state_q),
  .cnt_q      (cnt_q),
  .mv_req     (mv_req),
  .mv_ready   (mv_ready),
  .xfer_done  (xfer_done),
  .bus_rvalid (bus_rvalid),
  .bus_rdata  (bus_rdata)
);

// File: tb/test_proxy_dma_ctrl.sv
`timescale 1ns/1ps
module test_proxy_dma_ctrl;
  localparam int AW = 32;
  localparam logic [31:0] MP = 32'h8000_0000;
  localparam logic [31:0] DP = 32'hC000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        mv_req;
  logic        mv_ready = 1'b0;
  logic [31:0] mv_src_addr, mv_dst_addr;
  logic        xfer_done;

  int errors = 0;
  int checks = 0;
  int done_cnt = 0;
  bit finished = 1'b0;

  logic [31:0] exp_stat_q[$];
  string       exp_tag_q[$];
  logic [63:0] exp_beat_q[$];

  always #2 clk = ~clk;

  proxy_dma_ctrl #(.AW(AW), .PAGE_BYTES(4096)) i_proxy_dma_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .mv_req(mv_req), .mv_ready(mv_ready),
    .mv_src_addr(mv_src_addr), .mv_dst_addr(mv_dst_addr), .xfer_done(xfer_done)
  );

  function automatic logic [31:0] st(bit i, bit x, bit v, bit m, bit w, bit e, int rem);
    logic [31:0] s;
    s = '0;
    s[0] = i; s[1] = x; s[2] = v; s[3] = m; s[4] = w; s[5] = e;
    s[8 +: 13] = 13'(rem);
    return s;
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_store(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_load(input logic [31:0] a, input logic [31:0] exp, input string tag);
    exp_stat_q.push_back(exp);
    exp_tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  // monitor: just after each falling edge, inputs for the next rising edge are settled
  always begin
    @(negedge clk);
    #1;
    if (rst_n && bus_rvalid) begin
      if (exp_stat_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected status actual=%h expected=none", bus_rdata);
      end else begin
        check({32'h0, bus_rdata}, {32'h0, exp_stat_q.pop_front()}, exp_tag_q.pop_front());
      end
    end
    if (rst_n && mv_req && mv_ready) begin
      if (exp_beat_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected word actual=%h expected=none", {mv_src_addr, mv_dst_addr});
      end else begin
        check({mv_src_addr, mv_dst_addr}, exp_beat_q.pop_front(), "R10 word addresses");
      end
    end
    if (xfer_done) done_cnt++;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check({61'h0, mv_req, xfer_done, bus_rvalid}, 64'h0, "R1 outputs after reset");
    bus_load(MP | 32'h10, st(1,0,1,0,0,0,0), "R1 idle status");

    // R2: real-region accesses are silent and change nothing
    bus_store(32'h0000_1000, 32'd16);
    bus_load(32'h0000_2000, 32'h0, "R2 dummy");
    void'(exp_stat_q.pop_back()); void'(exp_tag_q.pop_back());
    bus_load(MP, st(1,0,1,0,0,0,0), "R2 real store ignored");

    // R3 overwrite, R5 launch, R9 match, R12 hold, R10/R11 move
    bus_store(DP | 32'h200, 32'd16);
    bus_store(DP | 32'h100, 32'd8);
    bus_load(MP | 32'h1000, st(0,0,0,0,0,0,8), "R5 launch status / R3 overwrite count");
    bus_load(MP | 32'h1000, st(1,1,0,1,0,0,8), "R9 match on base");
    bus_load(MP | 32'h1004, st(1,1,0,0,0,0,8), "R9 no match off base");
    bus_store(DP, 32'hFFFF_FFFC);
    bus_store(DP, 32'd16);
    bus_load(MP | 32'h1004, st(1,1,0,0,0,0,8), "R12 stores ignored while moving");
    check({mv_src_addr, mv_dst_addr}, {32'h0000_1000, 32'h4000_0100}, "R10 stalled addresses");
    exp_beat_q.push_back({32'h0000_1000, 32'h4000_0100});
    exp_beat_q.push_back({32'h0000_1004, 32'h4000_0104});
    mv_ready = 1'b1;
    @(negedge clk); #1;
    check({63'h0, xfer_done}, 64'h0, "R11 no early done");
    @(negedge clk); #1;
    check({62'h0, xfer_done, mv_req}, 64'h2, "R11 done after last word");
    @(negedge clk); #1;
    check({63'h0, xfer_done}, 64'h0, "R11 done is one cycle");
    bus_load(MP | 32'h1000, st(1,0,1,0,0,0,0), "R11 idle after done");

    // R6 same-window loads
    bus_store(MP | 32'h100, 32'd16);
    bus_load(MP | 32'h200, st(1,0,0,0,1,0,16), "R6 memory-memory rejected");
    bus_load(MP | 32'h200, st(1,0,1,0,0,0,0), "R6 idle after reject");
    bus_store(DP, 32'd8);
    bus_load(DP | 32'h4, st(1,0,0,0,1,0,8), "R6 device-device rejected");

    // R4 abort and zero store
    bus_store(DP, 32'd16);
    bus_store(DP, 32'hFFFF_FFFF);
    bus_load(MP, st(1,0,1,0,0,0,0), "R4 negative store aborts");
    bus_store(MP, 32'd0);
    bus_load(MP, st(1,0,1,0,0,0,0), "R4 zero store ignored when idle");
    bus_store(DP, 32'd8);
    bus_store(DP, 32'd0);
    exp_beat_q.push_back({32'h0000_3000, 32'h4000_0000});
    exp_beat_q.push_back({32'h0000_3004, 32'h4000_0004});
    bus_load(MP | 32'h3000, st(0,0,0,0,0,0,8), "R4 zero store keeps armed count");
    repeat (3) @(negedge clk);
    check(64'(done_cnt), 64'd2, "R11 second transfer completed");

    // R7 alignment and page checks
    bus_store(DP, 32'd6);
    bus_load(MP | 32'h100, st(1,0,0,0,0,1,6), "R7 count misaligned");
    bus_load(MP | 32'h100, st(1,0,1,0,0,0,0), "R7 idle after fault");
    bus_store(DP | 32'h2, 32'd8);
    bus_load(MP, st(1,0,0,0,0,1,8), "R7 destination misaligned");
    bus_store(DP, 32'd8);
    bus_load(MP | 32'h102, st(1,0,0,0,0,1,8), "R7 source misaligned");
    bus_store(DP | 32'hFF8, 32'd16);
    bus_load(MP, st(1,0,0,0,0,1,16), "R7 destination crosses page");
    bus_store(DP, 32'd16);
    bus_load(MP | 32'hFF8, st(1,0,0,0,0,1,16), "R7 source crosses page");

    // full page boundary transfer with ready held high
    for (int k = 0; k < 1024; k++)
      exp_beat_q.push_back({32'h0000_2000 + 32'(4*k), 32'h4000_0000 + 32'(4*k)});
    bus_store(DP, 32'd4096);
    bus_load(MP | 32'h2000, st(0,0,0,0,0,0,4096), "R7 full page accepted");
    repeat (1023) @(negedge clk);
    #1;
    check({63'h0, xfer_done}, 64'h0, "R11 full page not yet done");
    @(negedge clk); #1;
    check({63'h0, xfer_done}, 64'h1, "R11 full page done on time");
    @(negedge clk); #1;
    check(64'(exp_beat_q.size()), 64'd0, "R10 all words moved");
    check(64'(exp_stat_q.size()), 64'd0, "R8 all status words returned");

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule